// File: doc/BRIEF.md
# Manchester Timing Frame Transmitter

This block turns 32-bit timing words into self-clocking Manchester frames on one serial line, meant to feed a differential bus driver. A sequencer offers a word as four fields: a 4-bit machine selector, a 4-bit frame kind, an 8-bit event code and a 16-bit payload. The block queues the word and frames it. A frame is a start bit, the 32 data bits, an even-parity bit and a stop bit. Each bit is sent as two half-cells of opposite level.

Frames leave only on a fixed slot grid, with at most one frame per slot. A rising edge on the pulse-per-second input restarts the grid, so a frame waiting at that moment goes out on the edge itself. This keeps frames that mark milliseconds in phase with the second boundary. If a frame is already on the line when the pulse arrives, it runs to the end. The slot that the pulse opens is then unused, and the grid counts on from the pulse.

The word input is a valid/ready stream. `s_ready` is high while the queue has room, and a word moves on any cycle where `s_valid` and `s_ready` are both high. Back-pressure is advisory only: a producer that keeps `s_valid` high while `s_ready` is low loses that word, and the block raises a sticky overflow flag.

Top module: `man_frame_tx`

## Requirements
- R1: During and right after reset, `line_out` is low, `busy` is low, `idle` is high, `overflow` is low and `s_ready` is high.
- R2: A frame sends 35 bits in this order: a start bit of 1, then data bits 31 down to 0, then the parity bit, then a stop bit of 0. Data bits 31:28 are the selector, 27:24 the kind, 23:16 the code and 15:0 the payload.
- R3: Each bit takes two half-cells of HALF_CELL_CYC clocks each. A 1 is sent high then low, and a 0 is sent low then high. `line_out` shows the first half-cell starting in the cycle after the start edge.
- R4: The parity bit is the XOR of the 32 data bits, so the data bits and the parity bit together hold an even number of ones.
- R5: Whenever no frame is being sent, `line_out` stays low with no transitions.
- R6: Slot boundaries come every SLOT_CYC clocks, counted from the last re-phase. A frame starts only on a boundary, and at most one frame starts per slot.
- R7: If the queue is empty at a boundary, that slot sends nothing, even if a word arrives later in the same slot.
- R8: The clock edge that first samples `pps` high is a slot boundary. If the line is free and a word is queued, a frame starts on that edge.
- R9: If a frame is on the line when `pps` rises, it finishes unchanged and no frame starts at the rise. The next boundary is SLOT_CYC clocks after the rise.
- R10: The queue holds FIFO_DEPTH words and sends them in the order they were accepted. `s_ready` is low exactly while the queue is full.
- R11: A word offered while `s_ready` is low is dropped and never sent. This sets `overflow`, which stays high until reset.
- R12: `busy` is high from the start edge until the frame's 70 half-cells have been sent. `idle` is high when the queue is empty and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | A word is offered |
| s_ready | output | 1 | The queue has room |
| s_acc | input | 4 | Selector field, data bits 31:28 |
| s_kind | input | 4 | Frame kind field, data bits 27:24 |
| s_code | input | 8 | Event code field, data bits 23:16 |
| s_payload | input | 16 | Payload field, data bits 15:0 |
| pps | input | 1 | Pulse-per-second, synchronous to clk |
| line_out | output | 1 | Manchester serial line |
| busy | output | 1 | A frame is on the line |
| idle | output | 1 | Queue empty and line free |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
The bench builds the block with HALF_CELL_CYC=2, SLOT_CYC=160 and FIFO_DEPTH=4. With these values a frame lasts 140 clocks and leaves a 20-clock quiet gap in each slot. Every cycle of every slot can then be checked against a model of the line computed in the bench, over thousands of clocks. A four-entry queue fills in four pushes, so the full, drop and ordering cases come up inside one slot. The short slot also lets the bench place pulse-per-second edges both in an idle stretch and in the middle of a frame. A sweep over two dozen words covers all-ones, all-zeros and mixed field patterns for the bit order and parity.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int DATA_W     = 32;
  localparam int FRAME_BITS = DATA_W + 3;

  typedef struct packed {
    logic [3:0]  acc;
    logic [3:0]  kind;
    logic [7:0]  code;
    logic [15:0] payload;
  } tword_t;

  // start(1) | data MSB first | even parity | stop(0)
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [DATA_W-1:0] w);
    return {1'b1, w, ^w, 1'b0};
  endfunction
endpackage

// File: rtl/mtx_fifo.sv
module mtx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full);  // R11
endmodule

// File: rtl/mtx_slot_timer.sv
module mtx_slot_timer #(
  parameter int SLOT_CYC = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic pps,
  output logic slot_start
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [CW-1:0] cnt;
  logic          pps_q;
  logic          pps_rise;

  assign pps_rise   = pps & ~pps_q;
  assign slot_start = pps_rise | (cnt == CW'(SLOT_CYC-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pps_q <= 1'b0;
    end else begin
      pps_q <= pps;
      cnt   <= slot_start ? '0 : cnt + 1'b1;
    end
  end

  AST_SLOT_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(SLOT_CYC-1)); // R6
  AST_PPS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (pps && !pps_q) |=> (cnt == '0)); // R8
endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer
  import mtx_pkg::*;
#(
  parameter int HALF_CELL_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  output logic              busy,
  output logic              line
);
  localparam int HW = (HALF_CELL_CYC > 1) ? $clog2(HALF_CELL_CYC) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic                  busy_q, half_q, line_q;
  logic [HW-1:0]         cyc_q;
  logic [BW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] sh_q;

  logic                  n_busy, n_half, n_line;
  logic [HW-1:0]         n_cyc;
  logic [BW-1:0]         n_bit;
  logic [FRAME_BITS-1:0] n_sh;

  always_comb begin
    n_busy = busy_q;
    n_half = half_q;
    n_cyc  = cyc_q;
    n_bit  = bit_q;
    n_sh   = sh_q;
    if (start) begin
      n_busy = 1'b1;
      n_sh   = pack_frame(word);
      n_half = 1'b0;
      n_cyc  = '0;
      n_bit  = '0;
    end else if (busy_q) begin
      if (cyc_q == HW'(HALF_CELL_CYC-1)) begin
        n_cyc = '0;
        if (!half_q) begin
          n_half = 1'b1;
        end else begin
          n_half = 1'b0;
          n_sh   = sh_q << 1;
          if (bit_q == BW'(FRAME_BITS-1)) n_busy = 1'b0;
          else                            n_bit  = bit_q + 1'b1;
        end
      end else begin
        n_cyc = cyc_q + 1'b1;
      end
    end
    // first half-cell carries the bit value, second its complement
    n_line = n_busy & (n_sh[FRAME_BITS-1] ^ n_half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      line_q <= 1'b0;
      cyc_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= n_busy;
      half_q <= n_half;
      line_q <= n_line;
      cyc_q  <= n_cyc;
      bit_q  <= n_bit;
      sh_q   <= n_sh;
    end
  end

  assign busy = busy_q;
  assign line = line_q;

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q); // R9
  AST_MID_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && half_q && !$past(half_q)) |-> (line_q != $past(line_q))); // R3
  AST_FRAME_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !line_q); // R5
endmodule

// File: rtl/man_frame_tx.sv
module man_frame_tx
  import mtx_pkg::*;
#(
  parameter int HALF_CELL_CYC = 50,
  parameter int SLOT_CYC      = 6250,
  parameter int FIFO_DEPTH    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [3:0]  s_acc,
  input  logic [3:0]  s_kind,
  input  logic [7:0]  s_code,
  input  logic [15:0] s_payload,
  input  logic        pps,
  output logic        line_out,
  output logic        busy,
  output logic        idle,
  output logic        overflow
);
  tword_t      in_word;
  logic [DATA_W-1:0] head_word;
  logic        q_full, q_empty, wr_en, launch, slot_start, ser_busy, ovf_q;

  assign in_word = '{acc: s_acc, kind: s_kind, code: s_code, payload: s_payload};
  assign s_ready = ~q_full;
  assign wr_en   = s_valid & ~q_full;
  assign launch  = slot_start & ~q_empty & ~ser_busy;

  mtx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(in_word),
    .rd_en(launch), .rd_data(head_word), .full(q_full), .empty(q_empty)
  );

  mtx_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_slot (
    .clk(clk), .rst(rst), .pps(pps), .slot_start(slot_start)
  );

  mtx_serializer #(.HALF_CELL_CYC(HALF_CELL_CYC)) u_ser (
    .clk(clk), .rst(rst), .start(launch), .word(head_word),
    .busy(ser_busy), .line(line_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                       ovf_q <= 1'b0;
    else if (s_valid && q_full)    ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
  assign busy     = ser_busy;
  assign idle     = q_empty & ~ser_busy;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R11
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_ready) |=> overflow); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle |-> !line_out); // R12
endmodule

// File: tb/man_frame_tx_tb.sv
module man_frame_tx_tb;
  localparam int H  = 2;
  localparam int S  = 160;
  localparam int D  = 4;
  localparam int F  = 70 * H;

  logic clk = 0, rst = 1;
  logic s_valid = 0, pps = 0;
  logic [3:0] s_acc = 0, s_kind = 0;
  logic [7:0] s_code = 0;
  logic [15:0] s_payload = 0;
  logic s_ready, line_out, busy, idle, overflow;

  int cyc = 0, checks = 0, errors = 0;
  bit mon_en = 0, done = 0;
  int sched_st [64];
  logic [31:0] sched_w [64];
  int n_sched = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  man_frame_tx #(.HALF_CELL_CYC(H), .SLOT_CYC(S), .FIFO_DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_acc(s_acc), .s_kind(s_kind), .s_code(s_code), .s_payload(s_payload),
    .pps(pps), .line_out(line_out), .busy(busy), .idle(idle), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d got %0h exp %0h", tag, cyc, got, exp);
    end
  endtask

  function automatic logic [34:0] exp_frame(input logic [31:0] w);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 32; i++) p = p ^ w[i];
    return {1'b1, w, p, 1'b0};
  endfunction

  // Line model: every negedge compares against the scheduled frames.
  always @(negedge clk) begin
    if (mon_en && !done) begin
      bit act;
      logic e;
      act = 0; e = 1'b0;
      for (int k = 0; k < n_sched; k++) begin
        if (cyc >= sched_st[k] && cyc < sched_st[k] + F) begin
          int idx;
          logic [34:0] fr;
          idx = (cyc - sched_st[k]) / H;
          fr  = exp_frame(sched_w[k]);
          act = 1;
          e   = fr[34 - idx/2] ^ logic'(idx % 2);
        end
      end
      if (act) chk(line_out === e, "R2/R3/R4 line", int'(line_out), int'(e));
      else     chk(line_out === 1'b0, "R5/R6/R7/R8/R9 quiet line", int'(line_out), 0);
      chk(busy === act, "R12 busy", int'(busy), int'(act));
    end
  end

  task automatic sched(input int st, input logic [31:0] w);
    sched_st[n_sched] = st;
    sched_w[n_sched]  = w;
    n_sched++;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    s_valid = 1;
    {s_acc, s_kind, s_code, s_payload} = w;
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic pulse_pps();
    pps = 1;
    @(negedge clk);
    @(negedge clk);
    pps = 0;
  endtask

  function automatic logic [31:0] gen(input int k);
    if (k == 1) return 32'hFFFF_FFFF;
    if (k == 2) return 32'h0;
    return {4'(k), 4'(~k), 8'(k * 91), 16'(k * 7997 + 16'h5a3c)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, p, p2, p3, b;
    repeat (4) @(negedge clk);
    rst = 0;
    c0 = cyc;
    // R1 reset state
    chk(line_out === 0, "R1 line", int'(line_out), 0);
    chk(busy === 0, "R1 busy", int'(busy), 0);
    chk(idle === 1, "R1 idle", int'(idle), 1);
    chk(overflow === 0, "R1 overflow", int'(overflow), 0);
    chk(s_ready === 1, "R1 ready", int'(s_ready), 1);
    mon_en = 1;

    // R8: queued word waits for the pps edge, then launches on it
    push(32'hA5C3_1E07);
    chk(idle === 0, "R12 idle with queued word", int'(idle), 0);
    wait_cyc(c0 + 5);
    p = c0 + 6;
    sched(p, 32'hA5C3_1E07);
    pulse_pps();

    // R6: one frame per slot on the grid
    wait_cyc(p + 9);
    push(32'h1234_5678); push(32'hF00F_0FF0); push(32'h8000_0001);
    sched(p + S, 32'h1234_5678);
    sched(p + 2*S, 32'hF00F_0FF0);
    sched(p + 3*S, 32'h8000_0001);
    wait_cyc(p + 3*S + F + 1);
    chk(idle === 1, "R12 idle after drain", int'(idle), 1);
    // R7: slot p+4S is empty, checked by the line model

    // R10 / R11: fill, full, drop
    wait_cyc(p + 4*S + 5);
    for (int i = 0; i < D; i++) begin
      push(32'h0101_0000 * (i + 1) + 32'(i));
      sched(p + (5 + i)*S, 32'h0101_0000 * (i + 1) + 32'(i));
    end
    chk(s_ready === 0, "R10 ready low when full", int'(s_ready), 0);
    chk(overflow === 0, "R11 no overflow yet", int'(overflow), 0);
    push(32'hDEAD_BEEF);
    chk(overflow === 1, "R11 overflow on drop", int'(overflow), 1);
    wait_cyc(p + 5*S + 1);
    chk(s_ready === 1, "R10 ready after pop", int'(s_ready), 1);

    // R8: re-phase while idle, mid-slot
    wait_cyc(p + 9*S + 20);
    push(32'h3C3C_A001);
    wait_cyc(p + 9*S + 40);
    p2 = p + 9*S + 41;
    sched(p2, 32'h3C3C_A001);
    pulse_pps();

    // R9: pps during a frame; frame finishes, grid counts from the pulse
    wait_cyc(p2 + 9);
    push(32'h7E00_0042); push(32'h0C0D_E123);
    sched(p2 + S, 32'h7E00_0042);
    wait_cyc(p2 + S + 30);
    p3 = p2 + S + 31;
    sched(p3 + S, 32'h0C0D_E123);
    pulse_pps();
    chk(busy === 1, "R9 frame continues past pps", int'(busy), 1);

    // R2/R3/R4 sweep of field patterns
    b = p3 + S;
    for (int k = 1; k <= 24; k++) begin
      wait_cyc(b + (k - 1)*S + 10);
      push(gen(k));
      sched(b + k*S, gen(k));
    end
    wait_cyc(b + 26*S);
    chk(overflow === 1, "R11 overflow sticky", int'(overflow), 1);
    chk(idle === 1, "R12 idle at end", int'(idle), 1);
    chk(n_sched == 35, "R10 frame count", n_sched, 35);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule